// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block is the digital timing core of a 10-bit successive-approximation converter whose result leaves on a single serial pin. It counts a fixed 14-clock conversion frame. It drives the track/hold switch and presents a trial code to the converter's DAC. It uses the one-bit comparator decision to run a binary search, one bit per clock. Each decided bit goes out on the serial pin as soon as it is known, most significant bit first. The pin has a separate tri-state enable.

The frame is started by an active-low start line. The level of that line at the falling edge of the last frame clock selects what happens next. If the line is high, the block finishes the frame, tri-states the pin and goes idle (one conversion per request). If the line is low, the next frame follows with no gap. Holding the line low gives continuous conversions. Pulling it low late in a frame chains one more conversion. Work is split across both clock edges. The frame counter moves on rising edges. The hold switch, the trial code and the serial bit change on falling edges.

Top module: `sar_serial_seq`

## Requirements
- R1: In continuous operation, each frame lasts exactly 14 clocks, so the hold command rises once every 14 clocks.
- R2: While idle, a rising edge that samples the start line low becomes clock 1 of a frame. From that edge the serial pin is enabled.
- R3: The hold command rises on the falling edge of clock 3. It stays high until the rising edge of clock 14, where tracking resumes.
- R4: From clock 1 until the falling edge of clock 4, the enabled serial pin drives 0.
- R5: On the falling edges of clocks 4 to 13, the serial pin shows result bits 9 down to 0, one per edge. At the rising edge of clock 14 the pin returns to 0.
- R6: On the falling edge of clock 3, the trial code becomes 1000000000. On each falling edge of clocks 4 to 13, the bit under test is kept when the comparator input is 1 (analog input at or above the trial level) and cleared when it is 0, and the next lower bit is set to 1. The final code is plain binary, from 0 to 1023.
- R7: If the start line is high at the falling edge of clock 14, the pin is disabled from that edge and the block returns to idle.
- R8: If the start line is low at the falling edge of clock 14, the next rising edge is clock 1 of a new frame. The pin stays enabled and low across the boundary.
- R9: The final code is copied to the result output on the falling edge of clock 13. It holds that value until the same edge of the next frame.
- R10: An asynchronous active-low reset returns the block to idle at any time. After reset the pin is disabled, the serial bit and hold are 0, and the trial and result codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startN | input | 1 | Active-low start/continue request |
| cmpIn | input | 1 | Comparator decision, 1 = input at or above trial level |
| holdCtl | output | 1 | 1 = hold the sampled input, 0 = track |
| trialCode | output | 10 | Trial code for the DAC |
| serOut | output | 1 | Serial result bit |
| serOe | output | 1 | Enable for the serial pin driver |
| resultCode | output | 10 | Last completed conversion result |

## Verification
Most wrong internal states show up on the pins within half a clock. A frame counter that is off by one edge shifts the hold window or the serial bit positions, and the next half-cycle sample catches it. A wrong end-of-frame decision shows at the falling edge of clock 14 as a wrong pin enable, or one clock later as a missing or extra frame. A wrong trial bit first shows as a wrong serial bit on the next falling edge. The final code check in clock 13 catches it as well. Extreme codes 0 and 1023 and codes with alternating bits exercise every keep/clear decision in both directions.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;

  // Strobes from the frame controller to the datapath, valid for the
  // falling edge inside the current clock.
  typedef struct packed {
    logic loadTrial;  // sample clock: start a new search
    logic decide;     // a bit is being decided this clock
    logic lastBit;    // final decision of the frame
    logic showData;   // serial pin may show the data bit
  } sarStrobe_t;

endpackage

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
  import sar_serial_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int SAMPLE_CLK = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startN,
  output sarStrobe_t                  strb,
  output logic [$clog2(RES_BITS)-1:0] bitSel,
  output logic                        holdCtl,
  output logic                        serOe
);
  localparam int DecFirst = SAMPLE_CLK + 1;
  localparam int DecLast  = SAMPLE_CLK + RES_BITS;
  localparam int FrameLen = DecLast + 1;
  localparam int CW       = $clog2(FrameLen + 1);
  localparam int IW       = $clog2(RES_BITS);

  logic [CW-1:0] cnt;       // 0 = idle, 1..FrameLen = clock number
  logic          endLatch;  // start line was high at the last falling edge
  logic          holdReg;
  logic          inHold;
  logic          atEnd;

  assign atEnd  = (cnt == CW'(FrameLen));
  assign inHold = (cnt >= CW'(SAMPLE_CLK)) && (cnt <= CW'(DecLast));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (cnt == '0)    cnt <= startN ? '0 : CW'(1);
    else if (atEnd)        cnt <= endLatch ? '0 : CW'(1);
    else                   cnt <= cnt + 1'b1;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      endLatch <= 1'b0;
      holdReg  <= 1'b0;
    end else begin
      endLatch <= atEnd & startN;
      holdReg  <= inHold;
    end
  end

  always_comb begin
    strb.loadTrial = (cnt == CW'(SAMPLE_CLK));
    strb.showData  = (cnt >= CW'(DecFirst)) && (cnt <= CW'(DecLast));
    strb.decide    = strb.showData;
    strb.lastBit   = (cnt == CW'(DecLast));
    bitSel         = strb.decide ? IW'(DecLast - int'(cnt)) : '0;
  end

  assign holdCtl = holdReg & inHold;
  assign serOe   = (cnt != '0) & ~(atEnd & endLatch);

  assert_frame_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && !atEnd) |=> (cnt == $past(cnt) + 1'b1));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !startN) |=> (cnt == CW'(1) && serOe));

  assert_hold_by_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CW'(SAMPLE_CLK)) |-> holdCtl);

  assert_idle_after_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (atEnd && !serOe) |=> (cnt == '0));

  assert_chain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (atEnd && serOe) |=> (cnt == CW'(1)));

endmodule

// File: rtl/sar_search_dp.sv
module sar_search_dp
  import sar_serial_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmpIn,
  input  sarStrobe_t                  strb,
  input  logic [$clog2(RES_BITS)-1:0] bitSel,
  output logic [RES_BITS-1:0]         trialCode,
  output logic [RES_BITS-1:0]         resultCode,
  output logic                        dataBit
);
  localparam logic [RES_BITS-1:0] FirstTrial = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] trialReg;
  logic [RES_BITS-1:0] nextTrial;

  always_comb begin
    nextTrial = trialReg;
    for (int i = 0; i < RES_BITS; i++) begin
      if (i == int'(bitSel))          nextTrial[i] = cmpIn;
      else if (i + 1 == int'(bitSel)) nextTrial[i] = 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      trialReg   <= '0;
      resultCode <= '0;
      dataBit    <= 1'b0;
    end else if (strb.loadTrial) begin
      trialReg <= FirstTrial;
      dataBit  <= 1'b0;
    end else if (strb.decide) begin
      trialReg <= nextTrial;
      dataBit  <= cmpIn;
      if (strb.lastBit) resultCode <= nextTrial;
    end
  end

  assign trialCode = trialReg;

  assert_bit_follows_cmp_R5: assert property (@(negedge clk) disable iff (!rstN)
    strb.decide |=> (dataBit == $past(cmpIn)));

  assert_low_decision_clears_R6: assert property (@(negedge clk) disable iff (!rstN)
    (strb.decide && !cmpIn) |=> !trialReg[$past(bitSel)]);

  assert_result_held_R9: assert property (@(negedge clk) disable iff (!rstN)
    !strb.lastBit |=> $stable(resultCode));

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_serial_pkg::*;
#(
  parameter int RES_BITS   = 10,
  parameter int SAMPLE_CLK = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startN,
  input  logic                cmpIn,
  output logic                holdCtl,
  output logic [RES_BITS-1:0] trialCode,
  output logic                serOut,
  output logic                serOe,
  output logic [RES_BITS-1:0] resultCode
);
  localparam int IW = $clog2(RES_BITS);

  sarStrobe_t    strb;
  logic [IW-1:0] bitSel;
  logic          dataBit;

  sar_frame_ctrl #(.RES_BITS(RES_BITS), .SAMPLE_CLK(SAMPLE_CLK)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startN  (startN),
    .strb    (strb),
    .bitSel  (bitSel),
    .holdCtl (holdCtl),
    .serOe   (serOe)
  );

  sar_search_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmpIn      (cmpIn),
    .strb       (strb),
    .bitSel     (bitSel),
    .trialCode  (trialCode),
    .resultCode (resultCode),
    .dataBit    (dataBit)
  );

  assign serOut = dataBit & strb.showData;

  assert_pin_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !serOe |-> !serOut);

endmodule

// File: tb/test_sar_serial_seq.sv
module test_sar_serial_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startN = 1'b1;
  logic       cmpIn;
  logic       holdCtl, serOut, serOe;
  logic [9:0] trialCode, resultCode;

  int vin = 0;
  int nCmp = 0, nBad = 0;
  bit done = 0;

  // reference model state
  int  mK = 0, mCode = 0, mResult = 0, tickNo = 0, lastRise = -100;
  bit  mStop = 0, mChain = 0, prevHold = 0;
  int  codeQ[$];

  always #10 clk = ~clk;

  assign cmpIn = (vin >= int'(trialCode));

  sar_serial_seq i_sar_serial_seq (
    .clk(clk), .rstN(rstN), .startN(startN), .cmpIn(cmpIn),
    .holdCtl(holdCtl), .trialCode(trialCode), .serOut(serOut),
    .serOe(serOe), .resultCode(resultCode)
  );

  task automatic chk(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s t=%0t k=%0d actual=%0d expected=%0d", tag, $time, mK, act, exp);
    end
  endtask

  function automatic int bitOf(int code, int idx);
    return (code >> idx) & 1;
  endfunction

  task automatic checkIdle();
    chk("R10", serOe, 0);
    chk("R10", serOut, 0);
    chk("R10", holdCtl, 0);
    chk("R10", trialCode, 0);
    chk("R10", resultCode, 0);
  endtask

  function automatic string oeTag(bit lowHalf);
    if (mK == 0 || (lowHalf && mK == 14)) return "R7";
    return mChain ? "R8" : "R2";
  endfunction

  // one clock, entered and left at rising edge + 5 ns
  task automatic tick();
    chk(oeTag(0), serOe, int'(mK != 0));
    chk("R3", holdCtl, int'(mK >= 4 && mK <= 13));
    chk(mK <= 4 ? "R4" : "R5", serOut, (mK >= 5 && mK <= 13) ? bitOf(mCode, 14 - mK) : 0);
    if (mK == 1 && codeQ.size() > 0) vin = codeQ.pop_front();
    @(negedge clk);
    if (mK == 3) mCode = vin;
    if (mK == 13) mResult = mCode;
    mStop = (mK == 14) && startN;
    #5;
    chk(oeTag(1), serOe, int'(mK != 0 && !(mK == 14 && mStop)));
    chk("R3", holdCtl, int'(mK >= 3 && mK <= 13));
    chk(mK < 4 ? "R4" : "R5", serOut, (mK >= 4 && mK <= 13) ? bitOf(mCode, 13 - mK) : 0);
    chk(mK == 13 ? "R6" : "R9", resultCode, mResult);
    if (mK == 13) chk("R6", trialCode, mCode);
    if (holdCtl && !prevHold) begin
      if (mChain) chk("R1", tickNo - lastRise, 14);
      lastRise = tickNo;
    end
    prevHold = holdCtl;
    @(posedge clk);
    if (mK == 0) begin
      if (!startN) begin mK = 1; mChain = 0; end
    end else if (mK == 14) begin
      if (mStop) mK = 0;
      else begin mK = 1; mChain = 1; end
    end else mK++;
    #5;
    tickNo++;
  endtask

  task automatic singleShot(int code);
    codeQ.push_back(code);
    startN = 1'b0;
    tick();
    startN = 1'b1;
    repeat (16) tick();
  endtask

  initial begin
    #3;
    checkIdle();                       // R10 at power-up
    @(posedge clk); #5;
    rstN = 1'b1;
    repeat (3) tick();

    // R6 extremes and alternating patterns, one conversion per request (R7)
    singleShot(0);
    singleShot(1023);
    singleShot(512);
    singleShot(341);

    // continuous conversions, R8 and R1, then released mid-frame (R7)
    codeQ.push_back(682); codeQ.push_back(1);
    codeQ.push_back(1022); codeQ.push_back(5);
    startN = 1'b0;
    tick();
    repeat (42) tick();
    repeat (5) tick();
    startN = 1'b1;
    repeat (12) tick();

    // late re-request chains exactly one more frame (R8)
    codeQ.push_back(100); codeQ.push_back(900);
    startN = 1'b0;
    tick();
    startN = 1'b1;
    while (mK != 12) tick();
    startN = 1'b0;
    repeat (3) tick();
    startN = 1'b1;
    repeat (16) tick();

    // asynchronous reset in the middle of a frame (R10)
    codeQ.push_back(777);
    startN = 1'b0;
    tick();
    startN = 1'b1;
    repeat (6) tick();
    rstN = 1'b0;
    mK = 0; mStop = 0; mChain = 0; mResult = 0; mCode = 0;
    #2;
    checkIdle();
    @(posedge clk); #5;
    rstN = 1'b1;
    repeat (2) tick();
    singleShot(255);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule